// File: doc/BRIEF.md
# Presence-Vector Snoop Filter Directory

This block is a tag-only coherence directory placed beside the private caches of a multi-core chip. For every line that any core may hold, it keeps the line's tag and a vector with one bit per core. A set bit means that core might have a copy, whatever coherence state the line has inside that core's cache. The directory stores no line data.

Cores report three kinds of events: a fill (the core has brought the line in), a clean evict (the core has dropped the line), and a read-for-ownership (the core wants the only copy). An ownership request sends invalidations only to the other cores whose bits are set. There is no broadcast.

The directory is inclusive. When a miss lands in a full set, the least recently used entry is replaced, and every core recorded as holding that victim line is first told to invalidate it. Requests arrive one at a time on a valid/ready channel. While any invalidation round is outstanding, `req_ready` stays low, so later requests, including those to the set being worked on, wait at the edge. A request is taken on a cycle where `req_valid` and `req_ready` are both high. The response is a single-cycle pulse and has no back-pressure.

Top module: `snoop_dir`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Exactly one `rsp_valid` pulse follows, lasting one cycle and carrying the requester in `rsp_core`. If no invalidation is needed, the pulse comes in the cycle right after acceptance. Operation codes on `req_op` are 2'b00 fill, 2'b01 clean evict, 2'b10 read-for-ownership, and 2'b11 reserved. A reserved request is answered and changes nothing.
- R2: A fill sets the requester's presence bit. On a hit, the bit is merged into the existing vector. On a miss, a new entry is installed holding only the requester's bit.
- R3: A clean evict clears the requester's bit. When a vector reaches zero, the entry is freed. A miss with free ways takes the lowest-numbered free way and sends no invalidation. An evict of a line that is not tracked has no effect.
- R4: A read-for-ownership that hits raises `inv_vec` equal to the entry's presence bits minus the requester's own bit. `inv_addr` is set to the requested line. If that vector is empty, there is no invalidation phase.
- R5: After a read-for-ownership completes, the entry's presence vector holds only the requester's bit.
- R6: `inv_valid` stays high, with `inv_vec` and `inv_addr` stable, until every targeted core has pulsed its `inv_ack` bit. Only then is the response given. Acknowledges from cores that are not targeted are ignored.
- R7: A fill or ownership miss in a set with no free way picks the least recently used way. It back-invalidates every holder of that way, with `inv_addr` equal to the victim's line address, and then installs the new line in that way.
- R8: Fills and ownership requests that hit or install make that way the most recently used. Evicts do not change the recency order. At reset, way 0 is the newest and the highest way is the oldest.
- R9: `req_ready` is low from acceptance until the response cycle has ended, including the whole invalidation phase.
- R10: A core that holds a line always has that line's presence bit set. So every invalidation of that line names the core, unless the core is the ownership requester.
- R11: After reset, all entries are invalid, `req_ready` is high, and `inv_valid` and `rsp_valid` are low.

A line address is `{tag, set}`: the low log2(SETS) bits of `req_addr` select the set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can take a request |
| req_core | input | log2(CORES) | Requesting core |
| req_op | input | 2 | Operation code (see R1) |
| req_addr | input | ADDR_W | Line address |
| inv_valid | output | 1 | Invalidation round active |
| inv_vec | output | CORES | Cores that must invalidate |
| inv_addr | output | ADDR_W | Line to invalidate |
| inv_ack | input | CORES | Per-core invalidation acknowledge pulse |
| rsp_valid | output | 1 | Request completed (one cycle) |
| rsp_core | output | log2(CORES) | Core whose request completed |

## Verification
A corrupted presence vector shows up at the next ownership request or replacement of that line. It appears as an invalidation vector that misses a core still holding the line, or that names one that dropped it. The bench compares each vector against a reference directory and a per-core residency shadow, so the error is caught within one request. A wrong recency order shows as a wrong back-invalidation address at the first full-set miss in that set. A control fault shows within a cycle or two as a missing or early response, or as a lowered stall.

// File: rtl/snoop_dir_pkg.sv
package snoop_dir_pkg;
  typedef enum logic [1:0] {
    OP_FILL  = 2'b00,
    OP_EVICT = 2'b01,
    OP_RFO   = 2'b10,
    OP_NOP   = 2'b11
  } dir_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_INV  = 2'b01,
    ST_DONE = 2'b10
  } dir_state_e;
endpackage

// File: rtl/snoop_dir_tags.sv
module snoop_dir_tags #(
  parameter int CORES = 4,
  parameter int WAYS  = 4,
  parameter int SETS  = 8,
  parameter int TAG_W = 9,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [SET_W-1:0]                 rd_set,
  output logic [WAYS-1:0]                  rd_valid,
  output logic [WAYS-1:0][TAG_W-1:0]       rd_tag,
  output logic [WAYS-1:0][CORES-1:0]       rd_pres,
  input  logic                             wr_en,
  input  logic [SET_W-1:0]                 wr_set,
  input  logic [WAY_W-1:0]                 wr_way,
  input  logic                             wr_valid,
  input  logic [TAG_W-1:0]                 wr_tag,
  input  logic [CORES-1:0]                 wr_pres
);
  logic [WAYS-1:0]             valid_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
  logic [WAYS-1:0][CORES-1:0]  pres_q  [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        pres_q[s]  <= '0;
      end
    end else if (wr_en) begin
      valid_q[wr_set][wr_way] <= wr_valid;
      pres_q[wr_set][wr_way]  <= wr_pres;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_set];
  assign rd_tag   = tag_q[rd_set];
  assign rd_pres  = pres_q[rd_set];

  // R3: a live entry always has at least one holder
  p_live_has_holder_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_valid) |-> (wr_pres != '0));

  for (genvar w = 0; w < WAYS; w++) begin : g_free_chk
    // R3: a freed way carries no presence bits
    p_freed_is_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid[w] |-> (rd_pres[w] == '0));
  end
endmodule

// File: rtl/snoop_dir_lru.sv
module snoop_dir_lru #(
  parameter int WAYS = 4,
  parameter int SETS = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_set,
  output logic [WAY_W-1:0]  victim,
  input  logic              touch_en,
  input  logic [SET_W-1:0]  touch_set,
  input  logic [WAY_W-1:0]  touch_way
);
  logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
  logic [WAYS-1:0]            oldest;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      oldest[w] = (age_q[rd_set][w] == WAY_W'(WAYS - 1));
      if (oldest[w]) victim = WAY_W'(w);
    end
  end

  // R8: ages stay a permutation, so one way is oldest
  p_one_oldest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest));
endmodule

// File: rtl/snoop_dir_ctrl.sv
module snoop_dir_ctrl
  import snoop_dir_pkg::*;
#(
  parameter int CORES  = 4,
  parameter int WAYS   = 4,
  parameter int SETS   = 8,
  parameter int ADDR_W = 12,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - SET_W,
  localparam int WAY_W = $clog2(WAYS),
  localparam int CID_W = $clog2(CORES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [CID_W-1:0]            req_core,
  input  logic [1:0]                  req_op,
  input  logic [ADDR_W-1:0]           req_addr,
  output logic                        inv_valid,
  output logic [CORES-1:0]            inv_vec,
  output logic [ADDR_W-1:0]           inv_addr,
  input  logic [CORES-1:0]            inv_ack,
  output logic                        rsp_valid,
  output logic [CID_W-1:0]            rsp_core,
  output logic [SET_W-1:0]            rd_set,
  input  logic [WAYS-1:0]             rd_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  input  logic [WAYS-1:0][CORES-1:0]  rd_pres,
  input  logic [WAY_W-1:0]            lru_victim,
  output logic                        wr_en,
  output logic [SET_W-1:0]            wr_set,
  output logic [WAY_W-1:0]            wr_way,
  output logic                        wr_valid,
  output logic [TAG_W-1:0]            wr_tag,
  output logic [CORES-1:0]            wr_pres,
  output logic                        touch_en,
  output logic [SET_W-1:0]            touch_set,
  output logic [WAY_W-1:0]            touch_way
);
  dir_state_e          state_q;
  logic [SET_W-1:0]    req_set;
  logic [TAG_W-1:0]    req_tag;
  logic [CORES-1:0]    req_bit;
  logic [WAYS-1:0]     hit_vec;
  logic                hit, has_free;
  logic [WAY_W-1:0]    hit_way, free_way, alloc_way;
  logic [CORES-1:0]    inv_vec_d;
  logic [ADDR_W-1:0]   inv_addr_d;
  logic                need_inv;
  logic                allocating;

  dir_op_e             l_op;
  logic [CID_W-1:0]    l_core;
  logic [SET_W-1:0]    l_set;
  logic [TAG_W-1:0]    l_tag;
  logic [WAY_W-1:0]    l_way;
  logic                l_hit;
  logic [CORES-1:0]    l_pres, l_bit;
  logic [CORES-1:0]    vec_q, pend_q, pend_nx;
  logic [ADDR_W-1:0]   iaddr_q;

  assign req_set = req_addr[SET_W-1:0];
  assign req_tag = req_addr[ADDR_W-1:SET_W];
  assign req_bit = CORES'(1) << req_core;
  assign rd_set  = req_set;

  // Lookup of the addressed set
  always_comb begin
    hit_way  = '0;
    free_way = '0;
    has_free = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = rd_valid[w] && (rd_tag[w] == req_tag);
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!rd_valid[w]) begin
        free_way = WAY_W'(w);
        has_free = 1'b1;
      end
    end
    hit       = |hit_vec;
    alloc_way = has_free ? free_way : lru_victim;
  end

  // Which invalidation round, if any, the request needs
  always_comb begin
    inv_vec_d  = '0;
    inv_addr_d = req_addr;
    allocating = (req_op == OP_FILL) || (req_op == OP_RFO);
    if (req_op == OP_RFO && hit) begin
      inv_vec_d = rd_pres[hit_way] & ~req_bit;
    end else if (allocating && !hit && !has_free) begin
      inv_vec_d  = rd_pres[lru_victim];
      inv_addr_d = {rd_tag[lru_victim], req_set};
    end
    need_inv = |inv_vec_d;
  end

  assign pend_nx = pend_q & ~inv_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      l_op    <= OP_NOP;
      l_core  <= '0;
      l_set   <= '0;
      l_tag   <= '0;
      l_way   <= '0;
      l_hit   <= 1'b0;
      l_pres  <= '0;
      vec_q   <= '0;
      pend_q  <= '0;
      iaddr_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            l_op    <= dir_op_e'(req_op);
            l_core  <= req_core;
            l_set   <= req_set;
            l_tag   <= req_tag;
            l_hit   <= hit;
            l_way   <= hit ? hit_way : alloc_way;
            l_pres  <= hit ? rd_pres[hit_way] : '0;
            vec_q   <= inv_vec_d;
            pend_q  <= inv_vec_d;
            iaddr_q <= inv_addr_d;
            state_q <= need_inv ? ST_INV : ST_DONE;
          end
        end
        ST_INV: begin
          pend_q <= pend_nx;
          if (pend_nx == '0) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Directory update in the completion cycle
  assign l_bit = CORES'(1) << l_core;

  always_comb begin
    wr_en     = 1'b0;
    wr_valid  = 1'b0;
    wr_pres   = '0;
    touch_en  = 1'b0;
    wr_set    = l_set;
    wr_way    = l_way;
    wr_tag    = l_tag;
    touch_set = l_set;
    touch_way = l_way;
    if (state_q == ST_DONE) begin
      case (l_op)
        OP_FILL: begin
          wr_en    = 1'b1;
          wr_valid = 1'b1;
          wr_pres  = (l_hit ? l_pres : '0) | l_bit;
          touch_en = 1'b1;
        end
        OP_RFO: begin
          wr_en    = 1'b1;
          wr_valid = 1'b1;
          wr_pres  = l_bit;
          touch_en = 1'b1;
        end
        OP_EVICT: begin
          if (l_hit) begin
            wr_en    = 1'b1;
            wr_pres  = l_pres & ~l_bit;
            wr_valid = |(l_pres & ~l_bit);
          end
        end
        default: ;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign inv_valid = (state_q == ST_INV);
  assign inv_vec   = vec_q;
  assign inv_addr  = iaddr_q;
  assign rsp_valid = (state_q == ST_DONE);
  assign rsp_core  = l_core;

  // R2: a tag is present at most once in a set
  p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R1: the response lasts one cycle
  p_rsp_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9: no new request is taken during an invalidation round
  p_stall_in_inv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !req_ready);

  // R6: the round persists while any target has not acknowledged
  p_wait_all_acks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && ((pend_q & ~inv_ack) != '0)) |=> inv_valid);

  // R6: vector and line stay put during a round
  p_inv_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> (!inv_valid || ($stable(inv_vec) && $stable(inv_addr))));

  // R4: an ownership hit never targets its own requester
  p_rfo_skips_self_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && l_op == OP_RFO && l_hit) |-> !inv_vec[l_core]);

  // R7: an invalidation round always has a target
  p_round_has_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (inv_vec != '0));
endmodule

// File: rtl/snoop_dir.sv
module snoop_dir
  import snoop_dir_pkg::*;
#(
  parameter int CORES  = 4,
  parameter int WAYS   = 4,
  parameter int SETS   = 8,
  parameter int ADDR_W = 12,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - SET_W,
  localparam int WAY_W = $clog2(WAYS),
  localparam int CID_W = $clog2(CORES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [CID_W-1:0]   req_core,
  input  logic [1:0]         req_op,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               inv_valid,
  output logic [CORES-1:0]   inv_vec,
  output logic [ADDR_W-1:0]  inv_addr,
  input  logic [CORES-1:0]   inv_ack,
  output logic               rsp_valid,
  output logic [CID_W-1:0]   rsp_core
);
  logic [SET_W-1:0]            rd_set;
  logic [WAYS-1:0]             rd_valid;
  logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
  logic [WAYS-1:0][CORES-1:0]  rd_pres;
  logic [WAY_W-1:0]            lru_victim;
  logic                        wr_en, wr_valid;
  logic [SET_W-1:0]            wr_set;
  logic [WAY_W-1:0]            wr_way;
  logic [TAG_W-1:0]            wr_tag;
  logic [CORES-1:0]            wr_pres;
  logic                        touch_en;
  logic [SET_W-1:0]            touch_set;
  logic [WAY_W-1:0]            touch_way;

  snoop_dir_ctrl #(.CORES(CORES), .WAYS(WAYS), .SETS(SETS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk, .rst_n,
    .req_valid, .req_ready, .req_core, .req_op, .req_addr,
    .inv_valid, .inv_vec, .inv_addr, .inv_ack,
    .rsp_valid, .rsp_core,
    .rd_set, .rd_valid, .rd_tag, .rd_pres, .lru_victim,
    .wr_en, .wr_set, .wr_way, .wr_valid, .wr_tag, .wr_pres,
    .touch_en, .touch_set, .touch_way
  );

  snoop_dir_tags #(.CORES(CORES), .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk, .rst_n,
    .rd_set, .rd_valid, .rd_tag, .rd_pres,
    .wr_en, .wr_set, .wr_way, .wr_valid, .wr_tag, .wr_pres
  );

  snoop_dir_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk, .rst_n,
    .rd_set, .victim(lru_victim),
    .touch_en, .touch_set, .touch_way
  );
endmodule

// File: tb/tb_snoop_dir.sv
module tb_snoop_dir;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_core = '0;
  logic [1:0]  req_op = '0;
  logic [11:0] req_addr = '0;
  logic        inv_valid;
  logic [3:0]  inv_vec;
  logic [11:0] inv_addr;
  logic [3:0]  inv_ack = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_core;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  snoop_dir dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_core, .req_op, .req_addr,
    .inv_valid, .inv_vec, .inv_addr, .inv_ack, .rsp_valid, .rsp_core
  );

  localparam logic [1:0] FILL = 2'b00, EVICT = 2'b01, RFO = 2'b10, NOP = 2'b11;

  // reference directory
  bit          m_valid [8][4];
  logic [8:0]  m_tag   [8][4];
  logic [3:0]  m_pres  [8][4];
  int          m_age   [8][4];
  // per-core residency shadow
  bit          res     [4][4096];

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(input int tag, input int set);
    return {9'(tag), 3'(set)};
  endfunction

  task automatic m_touch(input int s, input int w);
    int a = m_age[s][w];
    for (int v = 0; v < 4; v++) begin
      if (v == w) m_age[s][v] = 0;
      else if (m_age[s][v] < a) m_age[s][v] = m_age[s][v] + 1;
    end
  endtask

  task automatic model_step(input int core, input logic [1:0] op, input logic [11:0] addr,
                            output logic [3:0] ev, output logic [11:0] ea);
    int s = int'(addr[2:0]);
    logic [8:0] t = addr[11:3];
    logic [3:0] cb = 4'b0001 << core;
    int h = -1;
    int w;
    ev = '0;
    ea = addr;
    for (int v = 0; v < 4; v++) if (m_valid[s][v] && m_tag[s][v] == t) h = v;
    if (op == FILL || op == RFO) begin
      if (h >= 0) begin
        if (op == RFO) begin
          ev = m_pres[s][h] & ~cb;
          m_pres[s][h] = cb;
        end else m_pres[s][h] = m_pres[s][h] | cb;
        m_touch(s, h);
      end else begin
        w = -1;
        for (int v = 3; v >= 0; v--) if (!m_valid[s][v]) w = v;
        if (w < 0) begin
          for (int v = 0; v < 4; v++) if (m_age[s][v] == 3) w = v;
          ev = m_pres[s][w];
          ea = {m_tag[s][w], 3'(s)};
        end
        m_valid[s][w] = 1'b1;
        m_tag[s][w]   = t;
        m_pres[s][w]  = cb;
        m_touch(s, w);
      end
    end else if (op == EVICT && h >= 0) begin
      m_pres[s][h] = m_pres[s][h] & ~cb;
      if (m_pres[s][h] == '0) m_valid[s][h] = 1'b0;
    end
  endtask

  task automatic do_req(input int core, input logic [1:0] op, input logic [11:0] addr, input string tag);
    logic [3:0]  ev;
    logic [11:0] ea;
    int left;
    string it;
    model_step(core, op, addr, ev, ea);
    it = (op == RFO && ea == addr) ? "R4" : "R7";
    @(negedge clk);
    chk(req_ready == 1'b1, {"R1 ready before request ", tag}, 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, {"R1 no stray response ", tag}, 32'(rsp_valid), 0);
    req_valid = 1'b1;
    req_core  = 2'(core);
    req_op    = op;
    req_addr  = addr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(inv_valid == (ev != '0), {it, " invalidate presence ", tag}, 32'(inv_valid), 32'(ev != '0));
    if (ev != '0 && inv_valid) begin
      chk(inv_vec == ev, {it, " invalidate vector ", tag}, 32'(inv_vec), 32'(ev));
      chk(inv_addr == ea, {it, " invalidate line ", tag}, 32'(inv_addr), 32'(ea));
      for (int c = 0; c < 4; c++) begin
        if (res[c][inv_addr] && !inv_vec[c] && !(op == RFO && c == core && inv_addr == addr))
          chk(1'b0, {"R10 holder left out ", tag}, 32'(inv_vec), 32'(c));
      end
      chk(req_ready == 1'b0, {"R9 stalled during round ", tag}, 32'(req_ready), 0);
      inv_ack = ~ev;
      @(negedge clk);
      inv_ack = '0;
      chk(inv_valid == 1'b1 && rsp_valid == 1'b0, {"R6 foreign ack ignored ", tag},
          32'({inv_valid, rsp_valid}), 32'b10);
      left = $countones(ev);
      for (int c = 0; c < 4; c++) begin
        if (ev[c]) begin
          repeat ($urandom % 3) @(negedge clk);
          inv_ack = 4'b0001 << c;
          @(negedge clk);
          inv_ack = '0;
          left--;
          if (left > 0)
            chk(inv_valid == 1'b1 && rsp_valid == 1'b0, {"R6 waits for every ack ", tag},
                32'({inv_valid, rsp_valid}), 32'b10);
        end
      end
      for (int c = 0; c < 4; c++) if (ev[c]) res[c][ea] = 1'b0;
    end
    chk(rsp_valid == 1'b1 && inv_valid == 1'b0, {"R1 response ", tag},
        32'({rsp_valid, inv_valid}), 32'b10);
    chk(rsp_core == 2'(core), {"R1 response core ", tag}, 32'(rsp_core), 32'(core));
    if (op == FILL || op == RFO) res[core][addr] = 1'b1;
    else if (op == EVICT) res[core][addr] = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    int core;
    int pick;
    logic [1:0] op;
    void'($urandom(32'd20417));
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 4; w++) begin
        m_valid[s][w] = 1'b0;
        m_tag[s][w]   = '0;
        m_pres[s][w]  = '0;
        m_age[s][w]   = w;
      end
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 4096; a++) res[c][a] = 1'b0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: state after reset
    chk(req_ready == 1'b1, "R11 ready after reset", 32'(req_ready), 1);
    chk(inv_valid == 1'b0, "R11 no invalidate after reset", 32'(inv_valid), 0);
    chk(rsp_valid == 1'b0, "R11 no response after reset", 32'(rsp_valid), 0);

    // R2: fills from three cores merge; R4/R5: ownership targets only others
    do_req(0, FILL, mk(1, 2), "R2 fill c0");
    do_req(1, FILL, mk(1, 2), "R2 fill c1");
    do_req(2, FILL, mk(1, 2), "R2 fill c2");
    do_req(1, RFO,  mk(1, 2), "R4 rfo c1");
    do_req(3, RFO,  mk(1, 2), "R5 rfo c3 sees only c1");
    do_req(3, RFO,  mk(1, 2), "R4 rfo sole owner no round");
    // R1: reserved code changes nothing
    do_req(0, NOP,  mk(1, 2), "R1 reserved op");
    do_req(2, RFO,  mk(1, 2), "R1 after reserved op");
    // R3: evict frees and the free way is reused without a round
    do_req(0, FILL, mk(2, 5), "R3 fill way0");
    do_req(1, FILL, mk(3, 5), "R3 fill way1");
    do_req(2, FILL, mk(4, 5), "R3 fill way2");
    do_req(3, FILL, mk(5, 5), "R3 fill way3");
    do_req(1, EVICT, mk(3, 5), "R3 evict frees");
    do_req(0, EVICT, mk(9, 5), "R3 evict absent line");
    do_req(0, FILL, mk(6, 5), "R3 reuse freed way");
    // R8: evict does not refresh; R7: LRU victim back-invalidated
    do_req(0, FILL, mk(2, 5), "R8 refresh tag2");
    do_req(2, EVICT, mk(9, 5), "R8 evict no touch");
    do_req(1, FILL, mk(7, 5), "R7 full set miss");
    do_req(2, RFO,  mk(8, 5), "R7 second victim");

    // Constrained random traffic over three sets with conflicts
    for (int i = 0; i < 900; i++) begin
      core = int'($urandom % 4);
      pick = int'($urandom % 8);
      op = (pick < 4) ? FILL : (pick < 6) ? EVICT : RFO;
      do_req(core, op, mk(int'($urandom % 6), (i % 3 == 0) ? 5 : int'($urandom % 2)), "R10 random");
    end

    @(negedge clk);
    chk(req_ready == 1'b1 && inv_valid == 1'b0, "R9 idle at end", 32'({req_ready, inv_valid}), 32'b10);
    finish_run();
  end
endmodule